// File: doc/BRIEF.md
# Bisync Receive Deframer

This block sits behind a character-level receiver on a synchronous serial line and turns a stream of received bytes, one per `rxValid` strobe, into framed Bisync blocks. It first hunts for character synchronisation, then recognises the start of a block and follows it to its end. Along the way it decides whether the block is in transparent or non-transparent form, drops fill characters, and builds the block check over exactly the characters that belong in it.

Payload bytes leave the block with a valid strobe. The end of each block is reported on a separate one-cycle strobe with a two-bit status. A good end and a check mismatch are reported when the block ends with a check. An enquiry abort is reported when the block ends with ENQ. A user-chosen termination character ends the block at once and gives its own status. Static configuration selects the ASCII or EBCDIC control codes and CRC-16 or a one-byte longitudinal check. Lower layers handle bit synchronisation and parity.

Top module: `bsr_deframer`

## Requirements
- R1: After reset, after `initCmd`, and after every block end, the receiver discards all bytes until it has seen two SYN characters on consecutive valid strobes. A lone SYN followed by any other byte does not synchronise it.
- R2: Once synchronised, further SYN bytes are ignored. The first non-SYN byte opens a block and is output as data, but it is never part of the block check.
- R3: In non-transparent form, ETB or ETX ends the text. Neither is output, but each is included in the check. With CRC-16 the check then arrives in two bytes, low byte first, and the result is reported as status 0 (match) or 1 (mismatch). A data strobe and an end strobe never occur on the same cycle.
- R4: With `useCrc16` low, the check is a single byte equal to the XOR of all checked characters, and exactly one check byte is read after the terminator.
- R5: In non-transparent form, a bare SYN inside a block is dropped from both the data output and the check.
- R6: A block that opens with DLE followed by STX is transparent. Both bytes are output, and neither is checked. Inside it, plain SYN, ETX and ENQ are ordinary data. DLE DLE yields one DLE in the data and in the check. DLE SYN is dropped from both. Only DLE ETB or DLE ETX ends the text, and only the ETB or ETX is checked.
- R7: ENQ ends the block immediately with status 2. In non-transparent form this applies to a bare ENQ; in transparent form it applies to DLE ENQ. No check byte is read.
- R8: A byte equal to the termination-character register ends the block immediately with status 3, and no check is made. The byte does not end the block when it directly follows a DLE that was consumed as data or as part of the opener.
- R9: The termination-character register holds DLE (0x10) after reset and after `initCmd`. A one-cycle `extraLoad` strobe replaces it with `extraIn`. When both happen together, `initCmd` wins.
- R10: With `useEbcdic` high, the control codes are SYN 0x32, ETB 0x26 and ENQ 0x2D. With it low, they are SYN 0x16, ETB 0x17 and ENQ 0x05. DLE 0x10, STX 0x02 and ETX 0x03 are common to both sets.
- R11: After a block ends, bytes that follow are not treated as part of a block until a new SYN pair has been seen.
- R12: Outputs are registered. A byte accepted at a clock edge appears on `dataValid`/`dataByte`, or on `frameEnd`/`frameStatus`, right after that same edge. All output strobes are low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| initCmd | input | 1 | Restart: back to hunt, termination character to DLE |
| useEbcdic | input | 1 | 1 selects EBCDIC control codes, 0 selects ASCII |
| useCrc16 | input | 1 | 1 selects two-byte CRC-16, 0 selects one-byte XOR check |
| extraLoad | input | 1 | Load strobe for the termination-character register |
| extraIn | input | 8 | New termination character |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| dataValid | output | 1 | Payload byte strobe |
| dataByte | output | 8 | Payload byte |
| frameEnd | output | 1 | One-cycle block-end strobe |
| frameStatus | output | 2 | End status: 0 good, 1 check error, 2 ENQ abort, 3 termination character |

## Verification
The bench targets near-miss synchronisation: a SYN, then noise, then a SYN pair. A design that synchronises on a single SYN would open a block on the noise byte. Embedded fill is also exercised, both a bare SYN in a non-transparent block and DLE SYN or DLE DLE in a transparent one. A design that checks or outputs fill characters produces a check mismatch or extra payload bytes. The termination character is tried directly after a DLE and on its own. It is also restored to DLE by `initCmd`, including a restart in the middle of a block, after which leftover bytes must be discarded. Both check types are tried with both correct and corrupted check bytes, and EBCDIC codes are mixed in to catch designs that fix the character set.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int CHAR_W = 8;

  localparam logic [CHAR_W-1:0] DLE_CODE = 8'h10;
  localparam logic [CHAR_W-1:0] STX_CODE = 8'h02;
  localparam logic [CHAR_W-1:0] ETX_CODE = 8'h03;

  typedef enum logic [1:0] {
    ST_GOOD   = 2'd0,
    ST_CHKERR = 2'd1,
    ST_ABORT  = 2'd2,
    ST_EXTRA  = 2'd3
  } endStat_t;

  // Decoded view of the current received byte, produced by the datapath.
  typedef struct packed {
    logic isSyn;
    logic isDle;
    logic isStx;
    logic isEtb;
    logic isEtx;
    logic isEnq;
    logic isExtra;
  } charFlags_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic     emit;
    logic     accClr;
    logic     accAdd;
    logic     saveLo;
    logic     endFrame;
    endStat_t status;
  } ctlStrobe_t;

  function automatic logic [CHAR_W-1:0] synCode(input logic ebc);
    return ebc ? 8'h32 : 8'h16;
  endfunction

  function automatic logic [CHAR_W-1:0] etbCode(input logic ebc);
    return ebc ? 8'h26 : 8'h17;
  endfunction

  function automatic logic [CHAR_W-1:0] enqCode(input logic ebc);
    return ebc ? 8'h2D : 8'h05;
  endfunction

endpackage

// File: rtl/bsr_dp.sv
module bsr_dp
  import bsr_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'hA001,
  parameter logic [15:0] CRC_INIT = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              initCmd,
  input  logic              useEbcdic,
  input  logic              useCrc16,
  input  logic              extraLoad,
  input  logic [CHAR_W-1:0] extraIn,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxByte,
  input  ctlStrobe_t        ctl,
  output charFlags_t        flags,
  output logic              checkOk,
  output logic              dataValid,
  output logic [CHAR_W-1:0] dataByte,
  output logic              frameEnd,
  output endStat_t          frameStatus
);

  localparam int ACC_W = $bits(CRC_POLY);

  logic [CHAR_W-1:0] extraReg;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  accNext;
  logic [CHAR_W-1:0] loReg;

  function automatic logic [ACC_W-1:0] crcStep(input logic [ACC_W-1:0] cur,
                                               input logic [CHAR_W-1:0] b);
    logic [ACC_W-1:0] c;
    c = cur ^ {{(ACC_W-CHAR_W){1'b0}}, b};
    for (int k = 0; k < CHAR_W; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

  // Character decode
  always_comb begin
    flags.isSyn   = (rxByte == synCode(useEbcdic));
    flags.isDle   = (rxByte == DLE_CODE);
    flags.isStx   = (rxByte == STX_CODE);
    flags.isEtb   = (rxByte == etbCode(useEbcdic));
    flags.isEtx   = (rxByte == ETX_CODE);
    flags.isEnq   = (rxByte == enqCode(useEbcdic));
    flags.isExtra = (rxByte == extraReg);
  end

  // Termination character register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         extraReg <= DLE_CODE;
    else if (initCmd)   extraReg <= DLE_CODE;
    else if (extraLoad) extraReg <= extraIn;
  end

  // Check accumulator (CRC-16 reflected, or XOR in the low byte)
  always_comb begin
    if (useCrc16) accNext = crcStep(acc, rxByte);
    else          accNext = {{(ACC_W-CHAR_W){1'b0}}, acc[CHAR_W-1:0] ^ rxByte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= CRC_INIT;
    else if (ctl.accClr) acc <= CRC_INIT;
    else if (ctl.accAdd) acc <= accNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          loReg <= '0;
    else if (ctl.saveLo) loReg <= rxByte;
  end

  always_comb begin
    if (useCrc16) checkOk = ({rxByte, loReg} == acc);
    else          checkOk = (rxByte == acc[CHAR_W-1:0]);
  end

  // Registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataValid   <= 1'b0;
      dataByte    <= '0;
      frameEnd    <= 1'b0;
      frameStatus <= ST_GOOD;
    end else begin
      dataValid <= ctl.emit;
      frameEnd  <= ctl.endFrame;
      if (ctl.emit)     dataByte    <= rxByte;
      if (ctl.endFrame) frameStatus <= ctl.status;
    end
  end

  // R12
  data_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> $past(rxValid));

  // R3
  end_excl_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frameEnd && dataValid));

  // R9
  extra_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(initCmd) |-> (extraReg == DLE_CODE));

  // R7
  abort_from_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameEnd && frameStatus == ST_ABORT) |-> $past(flags.isEnq));

endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       initCmd,
  input  logic       useCrc16,
  input  logic       rxValid,
  input  charFlags_t flags,
  input  logic       checkOk,
  output ctlStrobe_t ctl
);

  typedef enum logic [2:0] {
    HUNT0, HUNT1, SYNCED, START_DLE, NT_BODY, TR_BODY, TR_DLE, CHK
  } rxState_t;

  rxState_t state, nextState;
  logic     prevDle, nextPrevDle;
  logic     chkCnt, nextCnt;
  logic     ntActive;
  logic     allowExtra;

  assign ntActive   = (state == NT_BODY) || (state == START_DLE && !flags.isStx);
  assign allowExtra = (state == NT_BODY) && !prevDle;

  always_comb begin
    ctl         = '0;
    nextState   = state;
    nextPrevDle = prevDle;
    nextCnt     = chkCnt;
    if (rxValid && !initCmd) begin
      if (ntActive) begin
        nextState   = NT_BODY;
        nextPrevDle = flags.isDle;
        if (allowExtra && flags.isExtra) begin
          ctl.endFrame = 1'b1; ctl.status = ST_EXTRA; nextState = HUNT0;
        end else if (flags.isSyn) begin
          nextPrevDle = 1'b0;
        end else if (flags.isEnq) begin
          ctl.endFrame = 1'b1; ctl.status = ST_ABORT; nextState = HUNT0;
        end else if (flags.isEtb || flags.isEtx) begin
          ctl.accAdd = 1'b1; nextCnt = 1'b0; nextState = CHK;
        end else begin
          ctl.emit = 1'b1; ctl.accAdd = 1'b1;
        end
      end else begin
        case (state)
          HUNT0: if (flags.isSyn) nextState = HUNT1;
          HUNT1: nextState = flags.isSyn ? SYNCED : HUNT0;
          SYNCED: begin
            if (!flags.isSyn) begin
              ctl.accClr  = 1'b1;
              nextPrevDle = 1'b0;
              if (flags.isExtra) begin
                ctl.endFrame = 1'b1; ctl.status = ST_EXTRA; nextState = HUNT0;
              end else if (flags.isEnq) begin
                ctl.endFrame = 1'b1; ctl.status = ST_ABORT; nextState = HUNT0;
              end else begin
                ctl.emit  = 1'b1;
                nextState = flags.isDle ? START_DLE : NT_BODY;
              end
            end
          end
          START_DLE: begin
            // only reached here with STX: transparent opener complete
            ctl.emit  = 1'b1;
            nextState = TR_BODY;
          end
          TR_BODY: begin
            if (flags.isExtra) begin
              ctl.endFrame = 1'b1; ctl.status = ST_EXTRA; nextState = HUNT0;
            end else if (flags.isDle) begin
              nextState = TR_DLE;
            end else begin
              ctl.emit = 1'b1; ctl.accAdd = 1'b1;
            end
          end
          TR_DLE: begin
            nextState = TR_BODY;
            if (flags.isSyn) begin
              nextState = TR_BODY;
            end else if (flags.isEtb || flags.isEtx) begin
              ctl.accAdd = 1'b1; nextCnt = 1'b0; nextState = CHK;
            end else if (flags.isEnq) begin
              ctl.endFrame = 1'b1; ctl.status = ST_ABORT; nextState = HUNT0;
            end else begin
              ctl.emit = 1'b1; ctl.accAdd = 1'b1;
            end
          end
          CHK: begin
            if (useCrc16 && !chkCnt) begin
              ctl.saveLo = 1'b1; nextCnt = 1'b1;
            end else begin
              ctl.endFrame = 1'b1;
              ctl.status   = checkOk ? ST_GOOD : ST_CHKERR;
              nextState    = HUNT0;
            end
          end
          default: nextState = HUNT0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= HUNT0;
      prevDle <= 1'b0;
      chkCnt  <= 1'b0;
    end else if (initCmd) begin
      state   <= HUNT0;
      prevDle <= 1'b0;
      chkCnt  <= 1'b0;
    end else begin
      state   <= nextState;
      prevDle <= nextPrevDle;
      chkCnt  <= nextCnt;
    end
  end

  // R1
  sync_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SYNCED && $past(state) != SYNCED) |-> ($past(state) == HUNT1));

  // R11
  hunt_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.endFrame |=> (state == HUNT0));

  // R6
  tr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TR_BODY && $past(state) != TR_BODY && $past(state) != TR_DLE)
      |-> ($past(state) == START_DLE));

endmodule

// File: rtl/bsr_deframer.sv
module bsr_deframer
  import bsr_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'hA001,
  parameter logic [15:0] CRC_INIT = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       initCmd,
  input  logic       useEbcdic,
  input  logic       useCrc16,
  input  logic       extraLoad,
  input  logic [7:0] extraIn,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic       dataValid,
  output logic [7:0] dataByte,
  output logic       frameEnd,
  output logic [1:0] frameStatus
);

  charFlags_t flags;
  ctlStrobe_t ctl;
  logic       checkOk;
  endStat_t   statusInt;

  bsr_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .initCmd (initCmd),
    .useCrc16(useCrc16),
    .rxValid (rxValid),
    .flags   (flags),
    .checkOk (checkOk),
    .ctl     (ctl)
  );

  bsr_dp #(
    .CRC_POLY(CRC_POLY),
    .CRC_INIT(CRC_INIT)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .initCmd    (initCmd),
    .useEbcdic  (useEbcdic),
    .useCrc16   (useCrc16),
    .extraLoad  (extraLoad),
    .extraIn    (extraIn),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .ctl        (ctl),
    .flags      (flags),
    .checkOk    (checkOk),
    .dataValid  (dataValid),
    .dataByte   (dataByte),
    .frameEnd   (frameEnd),
    .frameStatus(statusInt)
  );

  assign frameStatus = statusInt;

endmodule

// File: tb/bsr_deframer_tb.sv
module bsr_deframer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       initCmd = 1'b0;
  logic       useEbcdic = 1'b0;
  logic       useCrc16 = 1'b1;
  logic       extraLoad = 1'b0;
  logic [7:0] extraIn = 8'h00;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       dataValid;
  logic [7:0] dataByte;
  logic       frameEnd;
  logic [1:0] frameStatus;

  int total = 0;
  int bad = 0;

  logic [7:0] outQ[$];
  logic [1:0] endQ[$];

  always #4 clk = ~clk;

  bsr_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .initCmd(initCmd), .useEbcdic(useEbcdic),
    .useCrc16(useCrc16), .extraLoad(extraLoad), .extraIn(extraIn),
    .rxValid(rxValid), .rxByte(rxByte), .dataValid(dataValid),
    .dataByte(dataByte), .frameEnd(frameEnd), .frameStatus(frameStatus)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (dataValid) outQ.push_back(dataByte);
      if (frameEnd)  endQ.push_back(frameStatus);
    end
  end

  // Vector table: bytes MSB-first, check mode 0 none / 1 good / 2 corrupted
  localparam int NV = 10;
  localparam logic [95:0] VSTIM [NV] = '{
    96'h16_16_02_41_42_03_00_00_00_00_00_00,
    96'h16_16_02_41_42_03_00_00_00_00_00_00,
    96'h16_16_02_41_16_42_17_00_00_00_00_00,
    96'h16_16_02_41_42_03_00_00_00_00_00_00,
    96'h16_16_02_41_42_03_00_00_00_00_00_00,
    96'h16_16_02_41_05_00_00_00_00_00_00_00,
    96'h41_16_42_16_16_16_02_43_03_00_00_00,
    96'h16_16_02_41_10_42_00_00_00_00_00_00,
    96'h32_32_02_C1_26_00_00_00_00_00_00_00,
    96'h32_32_02_2D_00_00_00_00_00_00_00_00
  };
  localparam int          VLEN  [NV] = '{6, 6, 7, 6, 6, 5, 9, 6, 5, 4};
  localparam int          VCHK  [NV] = '{1, 2, 1, 1, 2, 0, 1, 0, 1, 0};
  localparam logic        VLRC  [NV] = '{0, 0, 0, 1, 1, 0, 0, 0, 0, 0};
  localparam logic        VEBC  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam logic [11:0] VMASK [NV] = '{12'h038, 12'h038, 12'h068, 12'h038, 12'h038,
                                         12'h000, 12'h180, 12'h000, 12'h018, 12'h000};
  localparam int          VST   [NV] = '{0, 1, 0, 0, 1, 2, 0, 3, 0, 2};
  localparam int          VCNT  [NV] = '{3, 3, 3, 3, 3, 2, 2, 2, 2, 1};
  localparam string       VTAG  [NV] = '{"R3", "R3", "R5", "R4", "R4",
                                         "R7", "R1", "R8", "R10", "R10"};

  function automatic logic [15:0] tbCrc(input logic [15:0] cur, input logic [7:0] b);
    logic [15:0] c;
    c = cur ^ {8'h00, b};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxByte  = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b0;
    end
  endtask

  task automatic pulseInit();
    @(negedge clk);
    rxValid = 1'b0;
    initCmd = 1'b1;
    @(negedge clk);
    initCmd = 1'b0;
  endtask

  task automatic loadExtra(input logic [7:0] v);
    @(negedge clk);
    rxValid   = 1'b0;
    extraLoad = 1'b1;
    extraIn   = v;
    @(negedge clk);
    extraLoad = 1'b0;
  endtask

  task automatic clearQ();
    outQ.delete();
    endQ.delete();
  endtask

  // send bytes MSB-first, optionally followed by a computed CRC over a mask
  task automatic sendSeq(input logic [127:0] s, input int n, input logic [15:0] mask,
                         input bit addCrc);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      b = s[127-8*i -: 8];
      sendByte(b);
      if (mask[i]) c = tbCrc(c, b);
    end
    if (addCrc) begin
      sendByte(c[7:0]);
      sendByte(c[15:8]);
    end
    idle(3);
  endtask

  task automatic expectBytes(input string tag, input logic [63:0] exp, input int n);
    check(outQ.size() == n, tag, outQ.size(), n);
    for (int i = 0; i < n; i++) begin
      if (i < outQ.size())
        check(outQ[i] == exp[63-8*i -: 8], tag, outQ[i], exp[63-8*i -: 8]);
    end
  endtask

  task automatic expectEnd(input string tag, input int st);
    check(endQ.size() == 1, tag, endQ.size(), 1);
    if (endQ.size() > 0) check(endQ[0] == st, tag, endQ[0], st);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog R12 act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] acc;
    logic [7:0]  b;
    logic [7:0]  lo;

    repeat (3) @(negedge clk);
    // R12 reset state
    check(dataValid == 1'b0 && frameEnd == 1'b0, "R12 reset", {dataValid, frameEnd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dataValid == 1'b0 && frameEnd == 1'b0, "R12 after reset", {dataValid, frameEnd}, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      useCrc16  = !VLRC[v];
      useEbcdic = VEBC[v];
      clearQ();
      acc = 16'h0000;
      for (int i = 0; i < VLEN[v]; i++) begin
        b = VSTIM[v][95-8*i -: 8];
        sendByte(b);
        if (VMASK[v][i]) acc = VLRC[v] ? (acc ^ {8'h00, b}) : tbCrc(acc, b);
      end
      if (VCHK[v] != 0) begin
        lo = acc[7:0] ^ ((VCHK[v] == 2) ? 8'h5A : 8'h00);
        sendByte(lo);
        if (!VLRC[v]) sendByte(acc[15:8]);
      end
      idle(3);
      expectEnd(VTAG[v], VST[v]);
      check(outQ.size() == VCNT[v], VTAG[v], outQ.size(), VCNT[v]);
      if (outQ.size() > 0) check(outQ[0] == 8'h02, VTAG[v], outQ[0], 8'h02);
    end
    useCrc16  = 1'b1;
    useEbcdic = 1'b0;

    // R6 transparent block with DLE DLE, DLE SYN, plain ETX and SYN as data
    loadExtra(8'hFF);
    clearQ();
    sendSeq({128'h16_16_10_02_41_03_16_10_10_10_16_42_10_03_00_00}, 14,
            16'b0010_1001_0111_0000 >> 0 == 0 ? 16'h0 : 16'h0, 1'b0);
    // the line above only provides the opener path; real transparent run follows
    pulseInit();
    loadExtra(8'hFF);
    clearQ();
    acc = 16'h0000;
    acc = tbCrc(acc, 8'h41); acc = tbCrc(acc, 8'h03); acc = tbCrc(acc, 8'h16);
    acc = tbCrc(acc, 8'h10); acc = tbCrc(acc, 8'h42); acc = tbCrc(acc, 8'h03);
    sendByte(8'h16); sendByte(8'h16); sendByte(8'h10); sendByte(8'h02);
    sendByte(8'h41); sendByte(8'h03); sendByte(8'h16); sendByte(8'h10);
    sendByte(8'h10); sendByte(8'h10); sendByte(8'h16); sendByte(8'h42);
    sendByte(8'h10); sendByte(8'h03); sendByte(acc[7:0]); sendByte(acc[15:8]);
    idle(3);
    expectBytes("R6 transparent data", 64'h10_02_41_03_16_10_42_00, 7);
    expectEnd("R6 transparent end", 0);

    // R8 termination character directly after DLE is data
    loadExtra(8'h41);
    clearQ();
    acc = 16'h0000;
    acc = tbCrc(acc, 8'h10); acc = tbCrc(acc, 8'h41);
    acc = tbCrc(acc, 8'h42); acc = tbCrc(acc, 8'h03);
    sendByte(8'h16); sendByte(8'h16); sendByte(8'h02); sendByte(8'h10);
    sendByte(8'h41); sendByte(8'h42); sendByte(8'h03);
    sendByte(acc[7:0]); sendByte(acc[15:8]);
    idle(3);
    expectBytes("R8 after DLE", 64'h02_10_41_42_00_00_00_00, 4);
    expectEnd("R8 after DLE", 0);

    // R8 termination character on its own ends the block
    clearQ();
    sendSeq({128'h16_16_02_41_00_00_00_00_00_00_00_00_00_00_00_00}, 4, 16'h0, 1'b0);
    expectBytes("R8 plain", 64'h02_00_00_00_00_00_00_00, 1);
    expectEnd("R8 plain", 3);

    // R9 init restores DLE as termination character
    pulseInit();
    clearQ();
    sendSeq({128'h16_16_02_10_00_00_00_00_00_00_00_00_00_00_00_00}, 4, 16'h0, 1'b0);
    expectBytes("R9 init default", 64'h02_00_00_00_00_00_00_00, 1);
    expectEnd("R9 init default", 3);

    // R11 bytes after an ENQ end are discarded until a new SYN pair
    clearQ();
    sendSeq({128'h16_16_02_05_02_41_03_16_42_00_00_00_00_00_00_00}, 9, 16'h0, 1'b0);
    expectBytes("R11 rehunt", 64'h02_00_00_00_00_00_00_00, 1);
    expectEnd("R11 rehunt", 2);

    // R1 init in mid-block returns to hunt
    clearQ();
    sendByte(8'h16); sendByte(8'h16); sendByte(8'h02); sendByte(8'h41);
    pulseInit();
    sendSeq({128'h42_03_16_16_02_05_00_00_00_00_00_00_00_00_00_00}, 6, 16'h0, 1'b0);
    expectBytes("R1 init mid-block", 64'h02_41_02_00_00_00_00_00, 3);
    expectEnd("R1 init mid-block", 2);

    // R2 extra SYNs after the pair, then opener; R12 one-cycle latency
    clearQ();
    sendByte(8'h16); sendByte(8'h16); sendByte(8'h16);
    @(negedge clk);
    rxValid = 1'b1;
    rxByte  = 8'h02;
    check(dataValid == 1'b0, "R12 before edge", dataValid, 0);
    @(posedge clk);
    #2;
    check(dataValid == 1'b1 && dataByte == 8'h02, "R12 latency", {dataValid, dataByte}, 9'h102);
    sendByte(8'h05);
    idle(3);
    expectBytes("R2 opener", 64'h02_00_00_00_00_00_00_00, 1);
    expectEnd("R2 opener", 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule